// File: doc/BRIEF.md
# Command/Indication Channel Controller

This block serves the command/indication field of a time-multiplexed line frame. A frame strobe marks the boundary of each frame. On the transmit side the host writes a code into a holding register. At every frame strobe the block presents the held code on the line output, so the same code goes out in every frame until the host writes a different one.

On the receive side the block looks at the incoming field on every frame strobe. A value counts as new only when it differs from the value last accepted and the same value arrives in two consecutive frames. A changed value that is not confirmed in the following frame is discarded, and the value that arrives next becomes the new candidate. When a value is confirmed, the block stores it as the accepted code and sets a pending flag. The host clears the flag, and an enable bit gates it onto the interrupt line. A loopback control feeds the transmitted line code to the receiver in place of the line input.

Top module: `ci_channel`

## Requirements
- R1: After reset the accepted receive code is all ones (4'hF), the transmitted line code is all ones, and the pending flag is 0. A line that sits idle at all ones raises no interrupt.
- R2: A host write changes nothing on the line until the next frame strobe. From that strobe on, the written code appears on `txCode` and stays there across every later strobe until the host writes again.
- R3: A receive value that differs from the accepted code and arrives in two consecutive frame strobes is stored in `rxCode`. The store happens on the clock edge of the second strobe.
- R4: A changed value that is seen in only one frame is discarded. The next frame's value becomes the new candidate and needs its own confirming frame.
- R5: Values equal to the accepted code, however often they repeat, change nothing and set no interrupt.
- R6: Each acceptance sets `irqPending`. The flag stays set until `irqClr` is asserted. If an acceptance and a clear fall on the same cycle, the flag stays set.
- R7: `irq` equals `irqPending` while `irqEn` is 1 and is 0 while `irqEn` is 0.
- R8: While `loopEn` is 1, the receiver samples the current `txCode` instead of `lineRxCode`.
- R9: `rxCode` and `txCode` change only on cycles that carry a frame strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameTick | input | 1 | One-cycle strobe per frame |
| hostWr | input | 1 | Host write strobe for the transmit code |
| hostTxCode | input | CODE_W | Code written by the host |
| lineRxCode | input | CODE_W | Received field from the line |
| loopEn | input | 1 | Route the transmitted code to the receiver |
| irqEn | input | 1 | Interrupt enable |
| irqClr | input | 1 | Clear the pending flag |
| txCode | output | CODE_W | Code presented on the line |
| rxCode | output | CODE_W | Last accepted receive code |
| irqPending | output | 1 | Acceptance pending flag |
| irq | output | 1 | Gated interrupt |

## Verification
The bench builds the block with its default 4-bit code width. At that width the all-ones idle value, the single-frame glitch and the confirmation on the second frame can each be driven directly with small distinct codes. Loopback uses the same width, so a host-written code can be traced from the line output back into the accepted register. The case where an acceptance and a clear land on the same cycle is driven on purpose.

// File: rtl/ci_pkg.sv
package ci_pkg;
  typedef struct packed {
    logic loadTx;
    logic sendTx;
    logic loadCand;
    logic accept;
  } ciStrobe_t;
endpackage

// File: rtl/ci_ctrl.sv
module ci_ctrl
  import ci_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      frameTick,
  input  logic      hostWr,
  input  logic      eqAccepted,
  input  logic      eqCand,
  input  logic      irqClr,
  output ciStrobe_t strobe,
  output logic      pending
);
  logic candValid;

  always_comb begin
    strobe        = '0;
    strobe.loadTx = hostWr;
    strobe.sendTx = frameTick;
    if (frameTick && !eqAccepted) begin
      if (candValid && eqCand) strobe.accept   = 1'b1;
      else                     strobe.loadCand = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      candValid <= 1'b0;
      pending   <= 1'b0;
    end else begin
      if (frameTick) candValid <= strobe.loadCand;
      if (strobe.accept)  pending <= 1'b1;
      else if (irqClr)    pending <= 1'b0;
    end
  end
endmodule

// File: rtl/ci_datapath.sv
module ci_datapath
  import ci_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ciStrobe_t         strobe,
  input  logic [CODE_W-1:0] hostTxCode,
  input  logic [CODE_W-1:0] lineRxCode,
  input  logic              loopEn,
  output logic              eqAccepted,
  output logic              eqCand,
  output logic [CODE_W-1:0] txCode,
  output logic [CODE_W-1:0] rxCode
);
  localparam logic [CODE_W-1:0] IDLE = {CODE_W{1'b1}};

  logic [CODE_W-1:0] txHold;
  logic [CODE_W-1:0] cand;
  logic [CODE_W-1:0] sample;

  assign sample     = loopEn ? txCode : lineRxCode;
  assign eqAccepted = (sample == rxCode);
  assign eqCand     = (sample == cand);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txHold <= IDLE;
      txCode <= IDLE;
      cand   <= IDLE;
      rxCode <= IDLE;
    end else begin
      if (strobe.loadTx)   txHold <= hostTxCode;
      if (strobe.sendTx)   txCode <= txHold;
      if (strobe.loadCand) cand   <= sample;
      if (strobe.accept)   rxCode <= sample;
    end
  end
endmodule

// File: rtl/ci_channel.sv
module ci_channel
  import ci_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameTick,
  input  logic              hostWr,
  input  logic [CODE_W-1:0] hostTxCode,
  input  logic [CODE_W-1:0] lineRxCode,
  input  logic              loopEn,
  input  logic              irqEn,
  input  logic              irqClr,
  output logic [CODE_W-1:0] txCode,
  output logic [CODE_W-1:0] rxCode,
  output logic              irqPending,
  output logic              irq
);
  ciStrobe_t strobe;
  logic      eqAccepted;
  logic      eqCand;

  ci_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .frameTick(frameTick), .hostWr(hostWr),
    .eqAccepted(eqAccepted), .eqCand(eqCand), .irqClr(irqClr),
    .strobe(strobe), .pending(irqPending)
  );

  ci_datapath #(.CODE_W(CODE_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hostTxCode(hostTxCode),
    .lineRxCode(lineRxCode), .loopEn(loopEn), .eqAccepted(eqAccepted),
    .eqCand(eqCand), .txCode(txCode), .rxCode(rxCode)
  );

  assign irq = irqPending & irqEn;
endmodule

// File: rtl/ci_channel_chk.sv
module ci_channel_chk #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameTick,
  input logic              irqClr,
  input logic [CODE_W-1:0] txCode,
  input logic [CODE_W-1:0] rxCode,
  input logic              irqPending
);
  // R9: accepted code holds on cycles without a strobe
  assert_rx_only_on_tick_R9: assert property (@(posedge clk) disable iff (!rstN)
    !frameTick |=> $stable(rxCode));
  // R9: line code holds on cycles without a strobe
  assert_tx_only_on_tick_R9: assert property (@(posedge clk) disable iff (!rstN)
    !frameTick |=> $stable(txCode));
  // R6: a new accepted code comes with the pending flag
  assert_change_sets_pending_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxCode) |-> irqPending);
  // R6: the pending flag drops only after a clear
  assert_pending_clear_only_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqPending) |-> $past(irqClr));
  // R3: an accepted code changes only on the edge of a strobe cycle
  assert_accept_on_tick_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxCode) |-> $past(frameTick));
endmodule

bind ci_channel ci_channel_chk #(.CODE_W(CODE_W)) uChk (
  .clk(clk), .rstN(rstN), .frameTick(frameTick), .irqClr(irqClr),
  .txCode(txCode), .rxCode(rxCode), .irqPending(irqPending)
);

// File: tb/sim_ci_channel.sv
module sim_ci_channel;
  localparam int CODE_W = 4;

  logic clk = 0;
  logic rstN = 0;
  logic frameTick = 0, hostWr = 0, loopEn = 0, irqEn = 0, irqClr = 0;
  logic [CODE_W-1:0] hostTxCode = '0, lineRxCode = '1;
  logic [CODE_W-1:0] txCode, rxCode;
  logic irqPending, irq;

  int checks = 0, fails = 0;
  logic [CODE_W-1:0] expQ[$];
  logic [CODE_W-1:0] prevRx;

  always #5 clk = ~clk;

  ci_channel #(.CODE_W(CODE_W)) u0 (.*);

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: one frame with a given line value
  task automatic frame(input logic [CODE_W-1:0] v);
    @(posedge clk); #1;
    lineRxCode = v; frameTick = 1;
    @(posedge clk); #1;
    frameTick = 0;
    @(posedge clk); #1;
  endtask

  task automatic expectAccept(input logic [CODE_W-1:0] v);
    expQ.push_back(v);
  endtask

  // monitor: compares every change of the accepted code with the queue
  initial prevRx = '1;
  always @(negedge clk) begin
    if (rstN && rxCode !== prevRx) begin
      if (expQ.size() == 0) check(1'b0, "R4/R5 unexpected acceptance", rxCode, prevRx);
      else begin
        logic [CODE_W-1:0] e;
        e = expQ.pop_front();
        check(rxCode === e, "R3 accepted code", rxCode, e);
      end
      prevRx = rxCode;
    end
  end

  initial begin
    #2000000;
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    check(rxCode === 4'hF, "R1 reset rxCode", rxCode, 4'hF);
    check(txCode === 4'hF, "R1 reset txCode", txCode, 4'hF);
    check(irqPending === 1'b0, "R1 reset pending", irqPending, 0);

    repeat (3) frame(4'hF);
    @(negedge clk);
    check(irqPending === 1'b0, "R1 idle no interrupt", irqPending, 0);

    // glitch 5 then confirmed 7
    frame(4'h5);
    @(negedge clk);
    check(irqPending === 1'b0, "R4 single frame dropped", irqPending, 0);
    expectAccept(4'h7);
    frame(4'h7);
    @(negedge clk);
    check(rxCode === 4'hF, "R4 candidate reloaded", rxCode, 4'hF);
    frame(4'h7);
    @(negedge clk);
    check(irqPending === 1'b1, "R6 pending set", irqPending, 1);
    check(irq === 1'b0, "R7 gated off", irq, 0);
    irqEn = 1;
    @(negedge clk);
    check(irq === 1'b1, "R7 gated on", irq, 1);
    irqClr = 1; @(negedge clk); irqClr = 0; @(negedge clk);
    check(irqPending === 1'b0, "R6 cleared", irqPending, 0);

    // repeats of accepted value
    repeat (3) frame(4'h7);
    @(negedge clk);
    check(irqPending === 1'b0, "R5 same value no interrupt", irqPending, 0);

    // acceptance with simultaneous clear
    expectAccept(4'h3);
    frame(4'h3);
    @(posedge clk); #1;
    lineRxCode = 4'h3; frameTick = 1; irqClr = 1;
    @(posedge clk); #1;
    frameTick = 0; irqClr = 0;
    @(negedge clk);
    check(irqPending === 1'b1, "R6 set wins over clear", irqPending, 1);
    irqClr = 1; @(negedge clk); irqClr = 0;

    // transmit
    @(posedge clk); #1; hostTxCode = 4'hA; hostWr = 1;
    @(posedge clk); #1; hostWr = 0;
    repeat (3) @(negedge clk);
    check(txCode === 4'hF, "R2 no change before tick", txCode, 4'hF);
    lineRxCode = 4'h3;
    @(posedge clk); #1; frameTick = 1; @(posedge clk); #1; frameTick = 0;
    @(negedge clk);
    check(txCode === 4'hA, "R2 code on line", txCode, 4'hA);
    repeat (4) frame(4'h3);
    @(negedge clk);
    check(txCode === 4'hA, "R2 repeated every frame", txCode, 4'hA);

    // loopback
    loopEn = 1;
    expectAccept(4'hA);
    frame(4'h0);
    frame(4'h0);
    @(negedge clk);
    check(rxCode === 4'hA, "R8 loopback accepted", rxCode, 4'hA);
    loopEn = 0;

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R3 all expected acceptances seen", expQ.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule